// File: doc/BRIEF.md
# Dual-Channel Indirect Register Access Port

This block is the host-side front end of a two-channel serial controller. Each channel carries sixteen write registers and a small set of read registers, and all of it is reached through only four host addresses: every channel gets one control location and one data location. Most registers are reached indirectly. A write to a channel's control location with its register pointer at zero stores the byte as write register 0, and the low four bits of that byte become the pointer. The next control access on that channel, whether a read or a write, targets the register the pointer names, and the pointer then falls back to zero. The transmit and receive buffers can also be reached through the data location in one access, with no pointer set up.

The host does not need to space out its accesses. A parameterized recovery interval is enforced in hardware: after each completed access the ready output stays low for the programmed number of clock cycles, and a request held during that time simply waits. The serial engines themselves are not part of the block. They appear only as a receive-load strobe, a transmit-take strobe, the transmit byte and flags, and the transmit-enable bit.

Top module: `dual_chan_regport`

## Requirements
- R1: Host address 0 is the data location of channel A, 1 is the control location of channel A, 2 is the data location of channel B, and 3 is the control location of channel B. Every per-channel bus (rx_load, rx_char, tx_take, tx_byte, tx_full, tx_enable) keeps channel A in its low slice.
- R2: After reset, host_ready is high, tx_enable and tx_full are 0, and a control read of either channel returns 04h.
- R3: While a channel's pointer is zero, a control read returns status register 0. A control write stores the byte as write register 0 and loads the pointer with the byte's low four bits.
- R4: When the pointer is non-zero, the next control access on that channel reads or writes the register it selects, and the pointer then returns to zero.
- R5: The two channels have separate pointers and separate register banks. Setting the pointer or writing a register on one channel leaves the other channel unchanged.
- R6: Bit 3 of write register 5 drives that channel's tx_enable output.
- R7: Status bit 0 is set by an rx_load pulse, which captures rx_char. A data-location read, or a control read of register 8, returns the captured character and clears bit 0. If a load arrives in the same cycle as such a read, the load wins.
- R8: A data-location write, or a control write of register 8, fills the transmit buffer. This clears status bit 2, raises tx_full and places the byte on tx_byte. A tx_take pulse empties the buffer again.
- R9: Read registers 12, 13, 15 and 2 return the value last written to the write register with the same number. Read register 1 returns 01h. Read registers 3 and 10 and every other number return 00h.
- R10: After each completed access, host_ready stays low for exactly RECOVERY cycles. A request held during that time has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until accepted |
| host_addr | input | 2 | Location: bit 1 selects the channel, bit 0 selects control (1) or data (0) |
| host_wr | input | 1 | 1 for a write, 0 for a read |
| host_wdata | input | DATA_W | Write byte |
| host_rdata | output | DATA_W | Read byte, valid in the cycle an access is accepted; 0 otherwise |
| host_ready | output | 1 | High when a request is accepted at the next clock edge |
| rx_load | input | 2 | Per-channel pulse: a received character is available |
| rx_char | input | 2*DATA_W | Per-channel received character |
| tx_take | input | 2 | Per-channel pulse: the engine has taken the transmit byte |
| tx_byte | output | 2*DATA_W | Per-channel transmit buffer contents |
| tx_full | output | 2 | Per-channel transmit buffer holds a byte |
| tx_enable | output | 2 | Per-channel transmitter enable (write register 5 bit 3) |

## Verification
A pointer left armed, or one cleared too early, shows up on the very next control access on that channel. That access then reads or writes the wrong register, so the next read-back or status read returns the wrong byte. The checks therefore always follow a pointer sequence with a plain control read that must return status again. State crossing between the channels appears as soon as the other channel reads the register with the same number. A recovery counter that is off by one is caught by counting the low cycles of host_ready after one access. A request that slips through while the block is stalled shows up at once on tx_byte.

// File: rtl/regport_pkg.sv
package regport_pkg;
   // register numbers that carry behaviour
   localparam int REG_STATUS  = 0;
   localparam int REG_FIXED1  = 1;
   localparam int REG_VECTOR  = 2;
   localparam int REG_TXCTL   = 5;
   localparam int REG_BUF     = 8;
   localparam int REG_ECHO_A  = 12;
   localparam int REG_ECHO_B  = 13;
   localparam int REG_ECHO_C  = 15;
   // bit positions
   localparam int TXEN_BIT    = 3;
   localparam int ST_RXAVAIL  = 0;
   localparam int ST_TXEMPTY  = 2;

   typedef enum logic {
      LOC_DATA = 1'b0,
      LOC_CTRL = 1'b1
   } loc_kind_e;
endpackage

// File: rtl/regport_recovery.sv
module regport_recovery #(
   parameter int RECOVERY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic ready
);
   generate
      if (RECOVERY == 0) begin : g_free
         assign ready = 1'b1;
      end else begin : g_count
         localparam int CNT_W = $clog2(RECOVERY + 1);
         localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RECOVERY);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (req && ready)
               cnt_q <= CNT_LOAD;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign ready = (cnt_q == '0);

         // independent gap counter for checking the spacing
         logic [CNT_W-1:0] since_q;
         logic             seen_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               since_q <= '0;
               seen_q  <= 1'b0;
            end else if (req && ready) begin
               since_q <= '0;
               seen_q  <= 1'b1;
            end else if (since_q != CNT_LOAD) begin
               since_q <= since_q + 1'b1;
            end
         end

         a_r10_stall_after_access: assert property (@(posedge clk) disable iff (!rst_n)
            (req && ready) |=> !ready);
         a_r10_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            (req && ready && seen_q) |-> (since_q == CNT_LOAD));
         a_r10_idle_holds_ready: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && !req) |=> ready);
      end
   endgenerate
endmodule

// File: rtl/regport_chan.sv
module regport_chan
   import regport_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  loc_kind_e         loc,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_val,
   input  logic              rx_load,
   input  logic [DATA_W-1:0] rx_char,
   input  logic              tx_take,
   output logic [DATA_W-1:0] tx_byte,
   output logic              tx_full,
   output logic              tx_enable
);
   localparam int N_WR = 1 << PTR_W;
   localparam logic [PTR_W-1:0] BUF_SEL = PTR_W'(REG_BUF);

   logic [PTR_W-1:0]  ptr_q;
   logic [DATA_W-1:0] wreg_q [N_WR];
   logic [DATA_W-1:0] rx_q, tx_q;
   logic              rx_avail_q, tx_empty_q;
   logic [PTR_W-1:0]  sel;
   logic              wr_hit, rd_hit, tx_ld, rx_pop;
   logic [DATA_W-1:0] status;

   assign sel    = (loc == LOC_CTRL) ? ptr_q : BUF_SEL;
   assign wr_hit = acc && wr;
   assign rd_hit = acc && !wr;
   assign tx_ld  = wr_hit && (sel == BUF_SEL);
   assign rx_pop = rd_hit && (sel == BUF_SEL);

   // pointer: armed by a control write at zero, dropped by the next control access
   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (acc && loc == LOC_CTRL) begin
         if (ptr_q != '0)
            ptr_q <= '0;
         else if (wr)
            ptr_q <= wdata[PTR_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_WR; i++) wreg_q[i] <= '0;
      end else begin
         for (int i = 0; i < N_WR; i++)
            if (wr_hit && sel == PTR_W'(i) && i != REG_BUF)
               wreg_q[i] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_q       <= '0;
         rx_avail_q <= 1'b0;
      end else if (rx_load) begin
         rx_q       <= rx_char;
         rx_avail_q <= 1'b1;
      end else if (rx_pop) begin
         rx_avail_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q       <= '0;
         tx_empty_q <= 1'b1;
      end else if (tx_ld) begin
         tx_q       <= wdata;
         tx_empty_q <= 1'b0;
      end else if (tx_take) begin
         tx_empty_q <= 1'b1;
      end
   end

   always_comb begin
      status             = '0;
      status[ST_RXAVAIL] = rx_avail_q;
      status[ST_TXEMPTY] = tx_empty_q;
   end

   always_comb begin
      case (int'(sel))
         REG_STATUS: rd_val = status;
         REG_FIXED1: rd_val = DATA_W'(1);
         REG_VECTOR: rd_val = wreg_q[REG_VECTOR];
         REG_BUF:    rd_val = rx_q;
         REG_ECHO_A: rd_val = wreg_q[REG_ECHO_A];
         REG_ECHO_B: rd_val = wreg_q[REG_ECHO_B];
         REG_ECHO_C: rd_val = wreg_q[REG_ECHO_C];
         default:    rd_val = '0;
      endcase
   end

   assign tx_byte   = tx_q;
   assign tx_full   = !tx_empty_q;
   assign tx_enable = wreg_q[REG_TXCTL][TXEN_BIT];

   a_r4_ptr_returns_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && loc == LOC_CTRL && ptr_q != '0) |=> (ptr_q == '0));
   a_r3_ptr_only_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && loc == LOC_CTRL) |=> $stable(ptr_q));
   a_r7_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && !rx_load) |=> !rx_avail_q);
   a_r8_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ld |=> (tx_full && tx_byte == $past(wdata)));
endmodule

// File: rtl/dual_chan_regport.sv
module dual_chan_regport
   import regport_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PTR_W    = 4,
   parameter int RECOVERY = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_req,
   input  logic [1:0]          host_addr,
   input  logic                host_wr,
   input  logic [DATA_W-1:0]   host_wdata,
   output logic [DATA_W-1:0]   host_rdata,
   output logic                host_ready,
   input  logic [1:0]          rx_load,
   input  logic [2*DATA_W-1:0] rx_char,
   input  logic [1:0]          tx_take,
   output logic [2*DATA_W-1:0] tx_byte,
   output logic [1:0]          tx_full,
   output logic [1:0]          tx_enable
);
   localparam int N_CH = 2;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
      if (PTR_W < 4) begin : g_bad_ptr
         $error("PTR_W must be at least 4");
      end
      if (RECOVERY < 0) begin : g_bad_rec
         $error("RECOVERY must not be negative");
      end
   endgenerate

   logic              accept;
   loc_kind_e         loc;
   logic [DATA_W-1:0] ch_rd [N_CH];

   assign accept = host_req && host_ready;
   assign loc    = loc_kind_e'(host_addr[0]);

   regport_recovery #(.RECOVERY(RECOVERY)) u_rec (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (host_req),
      .ready (host_ready)
   );

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         regport_chan #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc       (accept && host_addr[1] == c[0]),
            .loc       (loc),
            .wr        (host_wr),
            .wdata     (host_wdata),
            .rd_val    (ch_rd[c]),
            .rx_load   (rx_load[c]),
            .rx_char   (rx_char[c*DATA_W +: DATA_W]),
            .tx_take   (tx_take[c]),
            .tx_byte   (tx_byte[c*DATA_W +: DATA_W]),
            .tx_full   (tx_full[c]),
            .tx_enable (tx_enable[c])
         );
      end
   endgenerate

   assign host_rdata = (accept && !host_wr) ? ch_rd[host_addr[1]] : '0;

   a_r1_data_b_write_fills_b: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && host_wr && host_addr == 2'd2) |=> tx_full[1]);
   a_r1_data_a_write_fills_a: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && host_wr && host_addr == 2'd0) |=> tx_full[0]);
endmodule

// File: tb/dual_chan_regport_test.sv
module dual_chan_regport_test;
   localparam int REC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic [1:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_ready;
   logic [1:0]  rx_load = '0;
   logic [15:0] rx_char = '0;
   logic [1:0]  tx_take = '0;
   logic [15:0] tx_byte;
   logic [1:0]  tx_full;
   logic [1:0]  tx_enable;

   int total = 0;
   int bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   dual_chan_regport #(.DATA_W(8), .PTR_W(4), .RECOVERY(REC)) uut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_addr(host_addr),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_ready(host_ready), .rx_load(rx_load), .rx_char(rx_char),
      .tx_take(tx_take), .tx_byte(tx_byte), .tx_full(tx_full), .tx_enable(tx_enable)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: pushes expected read data, then holds the request until accepted
   task automatic access(input logic [1:0] a, input logic w, input logic [7:0] d,
                         input logic [7:0] exp, input string tag);
      @(posedge clk); #1;
      host_req = 1'b1; host_addr = a; host_wr = w; host_wdata = d;
      if (!w) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
      end
      do @(negedge clk); while (!host_ready);
      @(posedge clk); #1;
      host_req = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      access(a, 1'b1, d, 8'h00, "");
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      access(a, 1'b0, 8'h00, exp, tag);
   endtask

   // monitor: compares each accepted read against the scoreboard
   always @(negedge clk) begin
      if (rst_n && host_req && host_ready && !host_wr) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL scoreboard: unexpected read actual=%0h expected=none", host_rdata);
         end else begin
            check(tag_q.pop_front(), {8'h00, host_rdata}, {8'h00, exp_q.pop_front()});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lows;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R2 ready after reset", {15'd0, host_ready}, 16'd1);
      check("R2 tx_enable after reset", {14'd0, tx_enable}, 16'd0);
      check("R2 tx_full after reset", {14'd0, tx_full}, 16'd0);
      rd(2'd1, 8'h04, "R2 R3 RR0 A after reset");
      rd(2'd3, 8'h04, "R2 R3 R1 RR0 B after reset");

      // R6 / R4: WR5 bit 3 through the pointer
      wr(2'd1, 8'h05);
      wr(2'd1, 8'h08);
      check("R6 tx_enable A", {14'd0, tx_enable}, 16'h0001);
      rd(2'd1, 8'h04, "R4 pointer back to zero");

      // R5: interleaved pointers on both channels
      wr(2'd1, 8'h0C);
      wr(2'd3, 8'h0D);
      wr(2'd1, 8'h5A);
      wr(2'd3, 8'hA5);
      wr(2'd1, 8'h0C); rd(2'd1, 8'h5A, "R5 R9 RR12 A");
      wr(2'd3, 8'h0D); rd(2'd3, 8'hA5, "R5 R9 RR13 B");
      wr(2'd1, 8'h0D); rd(2'd1, 8'h00, "R5 RR13 A untouched");
      check("R5 tx_enable B untouched", {14'd0, tx_enable}, 16'h0001);

      // R9: read register map
      wr(2'd1, 8'h04); wr(2'd1, 8'h77);
      wr(2'd1, 8'h04); rd(2'd1, 8'h00, "R9 RR4 unimplemented");
      wr(2'd1, 8'h01); rd(2'd1, 8'h01, "R9 RR1 fixed");
      wr(2'd1, 8'h0F); wr(2'd1, 8'h3C);
      wr(2'd1, 8'h0F); rd(2'd1, 8'h3C, "R9 RR15 echo");
      wr(2'd1, 8'h02); wr(2'd1, 8'h9E);
      wr(2'd1, 8'h02); rd(2'd1, 8'h9E, "R9 RR2 echo");

      // R7: receive buffer via data port and via pointer
      @(posedge clk); #1 rx_load = 2'b01; rx_char = 16'h0042;
      @(posedge clk); #1 rx_load = 2'b00;
      rd(2'd1, 8'h05, "R7 RR0 A rx avail");
      rd(2'd0, 8'h42, "R7 R1 data A pop");
      rd(2'd1, 8'h04, "R7 RR0 A after pop");
      @(posedge clk); #1 rx_load = 2'b10; rx_char = 16'h9900;
      @(posedge clk); #1 rx_load = 2'b00;
      wr(2'd3, 8'h08); rd(2'd3, 8'h99, "R7 RR8 B via pointer");
      rd(2'd3, 8'h04, "R7 RR0 B after pop");

      // R8: transmit buffer
      wr(2'd2, 8'h6E);
      check("R8 R1 tx_full B", {14'd0, tx_full}, 16'h0002);
      check("R8 tx_byte B", {8'h00, tx_byte[15:8]}, 16'h006E);
      rd(2'd3, 8'h00, "R8 RR0 B tx not empty");
      @(posedge clk); #1 tx_take = 2'b10;
      @(posedge clk); #1 tx_take = 2'b00;
      check("R8 tx_take empties B", {14'd0, tx_full}, 16'h0000);
      rd(2'd3, 8'h04, "R8 RR0 B after take");
      wr(2'd1, 8'h08); wr(2'd1, 8'h31);
      check("R8 WR8 via pointer A", {8'h00, tx_byte[7:0]}, 16'h0031);

      // R10: recovery count and a stalled request with no effect
      wr(2'd0, 8'h55);
      host_req = 1'b1; host_addr = 2'd0; host_wr = 1'b1; host_wdata = 8'hEE;
      lows = 0;
      forever begin
         @(negedge clk);
         if (host_ready) break;
         lows++;
      end
      host_req = 1'b0;
      check("R10 stall length", 16'(lows), 16'(REC));
      @(negedge clk);
      check("R10 stalled request ignored", {8'h00, tx_byte[7:0]}, 16'h0055);

      repeat (4) @(posedge clk);
      check("scoreboard drained", 16'(exp_q.size()), 16'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule